// File: doc/BRIEF.md
# Accumulator Machine Single-Step Executor

This block runs exactly one instruction of a small 16-bit accumulator machine each time it is started. It holds an 11-bit program counter, a 16-bit accumulator and a one-bit link flag. It reads instruction words from a synchronous memory whose address is always the current program counter. A start pulse makes the sequencer wait out the one-clock read latency and then decode the returned word. It then carries out an immediate load, a complemented immediate load or a direct jump. Any other word is refused and flagged as illegal.

Completion is signalled by a one-clock done pulse. A count of the machine cycles the instruction spent executing comes with it. A preload port writes the program counter, accumulator and link while the unit is idle, so a test harness can set up any starting state before each step.

Top module: `acc_step_unit`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, link, done, illegal flag and cycle count, and returns the unit to idle.
- R2: While idle, a high loadEn copies loadPc, loadAc and loadLink into the registers at the next clock edge. While a step is in progress, loadEn has no effect.
- R3: A word with bit 15 = 0 and bits 14:11 = 0001 loads the accumulator with bits 7:0 zero-extended. Bits 10:8 are ignored. The program counter advances by one, modulo 2048, and the cycle count is 1.
- R4: A word with bit 15 = 1 and bits 14:11 = 0001 loads the accumulator with the bitwise inverse of the zero-extended bits 7:0. An immediate of 0 gives 16'hFFFF and an immediate of 1 gives 16'hFFFE. The program counter advances by one and the cycle count is 1.
- R5: A word with bits 15:11 = 00010 loads the program counter with bits 10:0. The accumulator keeps its value and the cycle count is 2.
- R6: No instruction changes the link flag, whether it holds 0 or 1.
- R7: Every other word raises illegal together with done. The program counter and accumulator are left unchanged and the cycle count is 1. A legal completion clears illegal.
- R8: memAddr always equals the program counter. done is a single-clock pulse. It rises two rising edges after the edge that samples start for a one-cycle instruction, and three edges after for the jump. The program counter changes only at completion or on a preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one fetch-decode-execute step |
| loadEn | input | 1 | Preload strobe, honoured only while idle |
| loadPc | input | 11 | Program counter preload value |
| loadAc | input | 16 | Accumulator preload value |
| loadLink | input | 1 | Link preload value |
| memAddr | output | 11 | Instruction memory address |
| memRdData | input | 16 | Instruction word, one clock after the address |
| pc | output | 11 | Program counter |
| ac | output | 16 | Accumulator |
| link | output | 1 | Link flag |
| done | output | 1 | One-clock completion pulse |
| cycles | output | 3 | Machine cycles used by the last instruction |
| illegal | output | 1 | Last instruction was not recognised |

## Verification
A preload is visible one edge after loadEn is sampled. Results of a load or an illegal word appear with done two edges after the edge that samples start, and the results of a jump appear three edges after it. The bench drives inputs and samples outputs on the falling edge. It counts the falling edges from start to the first sight of done and compares that count with the expected latency. It reads the registers in the same half-cycle as done and checks that done has dropped one edge later. A sweep covers all 512 load words, all 2048 jump targets and every unsupported opcode pattern, and it predicts each result arithmetically from the instruction word.

// File: rtl/acc_step_pkg.sv
package acc_step_pkg;

  localparam logic [3:0] OPF_LOAD = 4'b0001;
  localparam logic [3:0] OPF_JUMP = 4'b0010;

  typedef enum logic [1:0] {
    OP_LOADIMM,
    OP_LOADCMP,
    OP_JUMP,
    OP_BAD
  } opKind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_JUMP
  } seqState_t;

  typedef struct packed {
    logic preload;
    logic acLoad;
    logic acInvert;
    logic pcInc;
    logic pcJump;
    logic irLoad;
  } ctlStrobes_t;

endpackage

// File: rtl/acc_step_decode.sv
module acc_step_decode
  import acc_step_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic [OPC_W:0] opTop,
  output opKind_t        kind
);

  logic          variantBit;
  logic [OPC_W-1:0] opField;

  assign variantBit = opTop[OPC_W];
  assign opField    = opTop[OPC_W-1:0];

  always_comb begin
    kind = OP_BAD;
    if (opField == OPC_W'(OPF_LOAD)) begin
      kind = variantBit ? OP_LOADCMP : OP_LOADIMM;
    end else if (opField == OPC_W'(OPF_JUMP) && !variantBit) begin
      kind = OP_JUMP;
    end
  end

endmodule

// File: rtl/acc_step_datapath.sv
module acc_step_datapath
  import acc_step_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       stb,
  input  logic [ADDR_W-1:0] loadPc,
  input  logic [DATA_W-1:0] loadAc,
  input  logic              loadLink,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ac,
  output logic              link
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] acNext;
  logic [ADDR_W-1:0] jumpTarget;

  assign immExt = {{PAD_W{1'b0}}, rdData[IMM_W-1:0]};
  assign acNext = stb.acInvert ? ~immExt : immExt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      ac         <= '0;
      link       <= 1'b0;
      jumpTarget <= '0;
    end else if (stb.preload) begin
      pc   <= loadPc;
      ac   <= loadAc;
      link <= loadLink;
    end else begin
      if (stb.acLoad) ac <= acNext;
      if (stb.pcInc) pc <= pc + 1'b1;
      else if (stb.pcJump) pc <= jumpTarget;
      if (stb.irLoad) jumpTarget <= rdData[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/acc_step_control.sv
module acc_step_control
  import acc_step_pkg::*;
#(
  parameter int CYC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             loadEn,
  input  opKind_t          kind,
  output ctlStrobes_t      stb,
  output logic             done,
  output logic [CYC_W-1:0] cycles,
  output logic             illegal
);

  seqState_t        state, stateNxt;
  logic             finish;
  logic [CYC_W-1:0] cycCnt;

  always_comb begin
    stb         = '0;
    stateNxt    = state;
    finish      = 1'b0;
    stb.preload = loadEn && (state == ST_IDLE);
    case (state)
      ST_IDLE:  if (start) stateNxt = ST_FETCH;
      ST_FETCH: stateNxt = ST_EXEC;
      ST_EXEC: begin
        case (kind)
          OP_LOADIMM: begin
            stb.acLoad = 1'b1;
            stb.pcInc  = 1'b1;
          end
          OP_LOADCMP: begin
            stb.acLoad   = 1'b1;
            stb.acInvert = 1'b1;
            stb.pcInc    = 1'b1;
          end
          OP_JUMP: stb.irLoad = 1'b1;
          default: ;
        endcase
        if (kind == OP_JUMP) begin
          stateNxt = ST_JUMP;
        end else begin
          stateNxt = ST_IDLE;
          finish   = 1'b1;
        end
      end
      ST_JUMP: begin
        stb.pcJump = 1'b1;
        finish     = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      cycCnt  <= '0;
      cycles  <= '0;
      illegal <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= finish;
      if (state == ST_FETCH) cycCnt <= '0;
      else if (state == ST_EXEC || state == ST_JUMP) cycCnt <= cycCnt + 1'b1;
      if (finish) begin
        cycles  <= cycCnt + 1'b1;
        illegal <= (state == ST_EXEC) && (kind == OP_BAD);
      end
    end
  end

endmodule

// File: rtl/acc_step_unit.sv
module acc_step_unit
  import acc_step_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int IMM_W  = 8,
  parameter int CYC_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadPc,
  input  logic [DATA_W-1:0] loadAc,
  input  logic              loadLink,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ac,
  output logic              link,
  output logic              done,
  output logic [CYC_W-1:0]  cycles,
  output logic              illegal
);

  localparam int OPC_W = DATA_W - ADDR_W - 1;

  ctlStrobes_t stb;
  opKind_t     kind;

  acc_step_decode #(.OPC_W(OPC_W)) u_decode (
    .opTop (memRdData[DATA_W-1:ADDR_W]),
    .kind  (kind)
  );

  acc_step_control #(.CYC_W(CYC_W)) u_control (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .loadEn  (loadEn),
    .kind    (kind),
    .stb     (stb),
    .done    (done),
    .cycles  (cycles),
    .illegal (illegal)
  );

  acc_step_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .loadPc   (loadPc),
    .loadAc   (loadAc),
    .loadLink (loadLink),
    .rdData   (memRdData),
    .pc       (pc),
    .ac       (ac),
    .link     (link)
  );

  assign memAddr = pc;

endmodule

// File: rtl/acc_step_checker.sv
module acc_step_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int CYC_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              loadEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] ac,
  input logic              link,
  input logic              done,
  input logic [CYC_W-1:0]  cycles,
  input logic              illegal
);

  logic pastValid;
  always_ff @(posedge clk) pastValid <= !rst;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_addr_follows_pc_R8: assert property (@(posedge clk) disable iff (rst)
    memAddr == pc);

  assert_pc_only_at_end_R8: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !$past(loadEn) && !done) |-> pc == $past(pc));

  assert_link_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !$past(loadEn)) |-> link == $past(link));

  assert_illegal_keeps_state_R7: assert property (@(posedge clk) disable iff (rst)
    (pastValid && done && illegal) |-> (pc == $past(pc) && ac == $past(ac) && cycles == 1));

  assert_jump_cost_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !illegal) |-> (cycles == 1 || cycles == 2));

endmodule

bind acc_step_unit acc_step_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_checker (
  .clk     (clk),
  .rst     (rst),
  .loadEn  (loadEn),
  .memAddr (memAddr),
  .pc      (pc),
  .ac      (ac),
  .link    (link),
  .done    (done),
  .cycles  (cycles),
  .illegal (illegal)
);

// File: tb/test_acc_step_unit.sv
module test_acc_step_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        loadEn;
  logic [10:0] loadPc;
  logic [15:0] loadAc;
  logic        loadLink;
  logic [10:0] memAddr;
  logic [15:0] memRdData;
  logic [10:0] pc;
  logic [15:0] ac;
  logic        link;
  logic        done;
  logic [2:0]  cycles;
  logic        illegal;

  int checks = 0;
  int fails  = 0;

  logic [15:0] mem [0:2047];

  always #5 clk = ~clk;

  always @(posedge clk) memRdData <= mem[memAddr];

  acc_step_unit i_acc_step_unit (
    .clk(clk), .rst(rst), .start(start), .loadEn(loadEn),
    .loadPc(loadPc), .loadAc(loadAc), .loadLink(loadLink),
    .memAddr(memAddr), .memRdData(memRdData),
    .pc(pc), .ac(ac), .link(link), .done(done), .cycles(cycles), .illegal(illegal)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [10:0] p, input logic [15:0] a, input logic l,
                      input logic [15:0] w, input bit poke);
    logic [10:0] pcE;
    logic [15:0] acE;
    int cycE, latE, edges;
    bit illE;
    string tag;
    mem[p] = w;
    if (w[14:11] == 4'b0001) begin
      acE  = {8'h00, w[7:0]};
      if (w[15]) acE = ~acE;
      pcE  = p + 11'd1;
      cycE = 1; latE = 2; illE = 0;
      tag  = w[15] ? "R4" : "R3";
    end else if (w[15:11] == 5'b00010) begin
      acE = a; pcE = w[10:0]; cycE = 2; latE = 3; illE = 0; tag = "R5";
    end else begin
      acE = a; pcE = p; cycE = 1; latE = 2; illE = 1; tag = "R7";
    end
    @(negedge clk);
    loadEn = 1'b1; loadPc = p; loadAc = a; loadLink = l;
    @(negedge clk);
    loadEn = 1'b0; start = 1'b1;
    check("R2", "preload pc", 32'(pc), 32'(p));
    check("R2", "preload ac", 32'(ac), 32'(a));
    check("R2", "preload link", 32'(link), 32'(l));
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    if (poke) begin
      loadEn = 1'b1; loadPc = ~p; loadAc = ~a; loadLink = ~l;
    end
    while (!done && edges < 12) begin
      @(negedge clk);
      edges++;
      loadEn = 1'b0;
    end
    check("R8", "done latency", 32'(edges), 32'(latE));
    check(tag, "pc", 32'(pc), 32'(pcE));
    check(tag, "ac", 32'(ac), 32'(acE));
    check("R6", "link", 32'(link), 32'(l));
    check(tag, "cycles", 32'(cycles), 32'(cycE));
    check("R7", "illegal flag", 32'(illegal), 32'(illE));
    if (poke) check("R2", "busy preload ignored pc", 32'(pc), 32'(pcE));
    @(negedge clk);
    check("R8", "done single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
    rst = 1'b1; start = 1'b0; loadEn = 1'b0;
    loadPc = '0; loadAc = '0; loadLink = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "reset pc", 32'(pc), 32'd0);
    check("R1", "reset ac", 32'(ac), 32'd0);
    check("R1", "reset link", 32'(link), 32'd0);
    check("R1", "reset done", 32'(done), 32'd0);
    check("R1", "reset illegal", 32'(illegal), 32'd0);
    check("R8", "memAddr follows pc", 32'(memAddr), 32'(pc));

    // R3 / R4: every immediate, both variants, with junk in bits 10:8
    for (int n = 0; n < 256; n++) begin
      for (int c = 0; c < 2; c++) begin
        step(11'((n * 9 + c) % 2048), 16'h29E5 ^ 16'(n * 131), n[0] ^ c[0],
             {c[0], 4'b0001, 3'(n + c), 8'(n)}, 1'b0);
      end
    end
    // R3: program counter wrap at the top of memory
    step(11'h7FF, 16'h1234, 1'b1, 16'h0855, 1'b0);
    // R4: listed corner values
    step(11'h040, 16'h0A0A, 1'b0, 16'h8800, 1'b0);
    step(11'h041, 16'h0A0A, 1'b1, 16'h8801, 1'b0);
    // R5: every jump target
    for (int t = 0; t < 2048; t++) begin
      step(11'((t * 5 + 3) % 2048), 16'(t * 37) ^ 16'hA5A5, t[1], {5'b00010, 11'(t)}, 1'b0);
    end
    // R7: every unsupported pattern of bits 15:11
    for (int h = 0; h < 32; h++) begin
      if (h != 5'b00001 && h != 5'b10001 && h != 5'b00010) begin
        step(11'(h * 61), 16'(h * 1001), h[0], {5'(h), 11'(h * 13 + 5)}, 1'b0);
      end
    end
    // R7: a legal completion clears illegal (after the last illegal word)
    step(11'h100, 16'h5555, 1'b0, 16'h0812, 1'b0);
    // R2: preload attempts during a step are ignored
    step(11'h200, 16'hBEEF, 1'b1, 16'h0877, 1'b1);
    step(11'h300, 16'hCAFE, 1'b0, {5'b00010, 11'h123}, 1'b1);
    // R1: reset after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "re-reset pc", 32'(pc), 32'd0);
    check("R1", "re-reset ac", 32'(ac), 32'd0);
    check("R1", "re-reset cycles", 32'(cycles), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule